// File: doc/BRIEF.md
# Event Counter Bank

A bank of eight 64-bit event counters for monitoring activity in a shared fabric. A wide vector of single-cycle event pulses enters the block. Each counter watches one of those lines, chosen by an 8-bit code. Software sets the bank up through a register port with one-cycle writes and combinational reads. The port is 32 bits wide for control registers and 64 bits wide for the counters.

Counting needs two enables: a global one and one per counter. When a counter wraps from all ones to zero it latches a status bit. Each status bit is cleared by writing a one to it. An active-high mask decides which status bits reach the single interrupt output. Software can preset any counter, which lets it arrange an interrupt after a chosen number of events.

Register offsets (byte addresses): control 0x000 (bit 0 global enable), counter enables 0x004, interrupt mask 0x008, interrupt status 0x00C (read-only), status clear 0x010 (write-only), identifier 0x014 (read-only), code selects 0x020 and 0x024, counter n at 0x100 + 8·n.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, every counter reads 0, the control and enable registers read 0, status reads 0, the mask reads 0xFF and irq_o is low.
- R2: Counter n counts evt_i[code], where code is byte lane n mod 4 of the select register at 0x020 + 4·(n div 4). A counter advances by at most one per clock, on the edge at which its selected line is high.
- R3: A counter advances only when bit 0 of 0x000 and bit n of 0x004 are both set. If either bit is clear, the counter holds its value.
- R4: A counter whose code is 0x80 or above never advances, whatever the event lines do.
- R5: A 64-bit write to 0x100 + 8·n loads counter n. A read of that address returns the counter value.
- R6: If a software write to a counter and an increment of that counter fall in the same cycle, the written value is kept.
- R7: When an increment takes a counter from all ones to zero, status bit n (read at 0x00C) is set on that same edge.
- R8: irq_o is high exactly when some status bit n is set and mask bit n at 0x008 is 0. Writing 1 to a mask bit suppresses that counter's interrupt without changing its status bit.
- R9: Writing 1 to bit n of 0x010 clears status bit n. Zero bits leave status unchanged. A wrap in the same cycle as the clear leaves the bit set.
- R10: Reading 0x014 returns the VERSION parameter (default 0x00020001). Writes to that address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event pulse lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | CTR_W | Write data (control registers use bits 31:0) |
| rdata_o | output | CTR_W | Combinational read data for addr_i |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A wrong count, a wrong code lane or a missed enable shows up in a counter's readback at the next read. The error accumulates, so a random run of a few hundred cycles makes it large. A wrong wrap or clear priority shows up in the status register and irq_o on the cycle right after the edge concerned. A mask error shows up on irq_o while the status bits are unchanged. The directed cases preset counters just below all ones, so each wrap lands on a known edge.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int OFF_CTRL = 'h000;
  localparam int OFF_CEN  = 'h004;
  localparam int OFF_MASK = 'h008;
  localparam int OFF_STAT = 'h00C;
  localparam int OFF_CLR  = 'h010;
  localparam int OFF_VER  = 'h014;
  localparam int OFF_SEL  = 'h020;
  localparam int OFF_CNT  = 'h100;
  localparam int LANE_W   = 8;
  localparam int LANES    = 4;
endpackage

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic               glb_en_o,
  output logic [NUM_CTR-1:0] ctr_en_o,
  output logic [NUM_CTR-1:0] mask_o,
  output logic [NUM_CTR-1:0] clr_o,
  output logic [NUM_CTR-1:0] cnt_wr_o,
  output logic [LANE_W-1:0]  code_o [NUM_CTR]
);
  logic wr;
  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_o <= 1'b0;
      ctr_en_o <= '0;
      mask_o   <= '1;
    end else if (wr) begin
      if (addr_i == ADDR_W'(OFF_CTRL)) glb_en_o <= wdata_i[0];
      if (addr_i == ADDR_W'(OFF_CEN))  ctr_en_o <= wdata_i[NUM_CTR-1:0];
      if (addr_i == ADDR_W'(OFF_MASK)) mask_o   <= wdata_i[NUM_CTR-1:0];
    end
  end

  assign clr_o = (wr && addr_i == ADDR_W'(OFF_CLR)) ? wdata_i[NUM_CTR-1:0] : '0;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_sel
    localparam int SEL_IDX = k / LANES;
    localparam int LANE    = k % LANES;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_o[k] <= '0;
      else if (wr && addr_i == ADDR_W'(OFF_SEL + 4*SEL_IDX))
        code_o[k] <= wdata_i[LANE*LANE_W +: LANE_W];
    end
    assign cnt_wr_o[k] = wr && (addr_i == ADDR_W'(OFF_CNT + 8*k));
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CTR_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CTR_W-1:0] wdata_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic             wrap_o
);
  // software write wins over an increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (wr_i)  cnt_o <= wdata_i;
    else if (inc_i) cnt_o <= cnt_o + CTR_W'(1);
  end

  assign wrap_o = inc_i & ~wr_i & (&cnt_o);
endmodule

// File: rtl/evt_irq.sv
module evt_irq #(
  parameter int NUM_CTR = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CTR-1:0] wrap_i,
  input  logic [NUM_CTR-1:0] clr_i,
  input  logic [NUM_CTR-1:0] mask_i,
  output logic [NUM_CTR-1:0] stat_o,
  output logic               irq_o
);
  // a wrap in the clear cycle keeps its bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr_i) | wrap_i;
  end

  assign irq_o = |(stat_o & ~mask_i);
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_pkg::*;
#(
  parameter int          NUM_CTR = 8,
  parameter int          CTR_W   = 64,
  parameter int          NUM_EVT = 128,
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] VERSION = 32'h0002_0001
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CTR_W-1:0]   wdata_i,
  output logic [CTR_W-1:0]   rdata_o,
  output logic               irq_o
);
  localparam int IDX_W = $clog2(NUM_EVT);

  logic                     glb_en;
  logic [NUM_CTR-1:0]       ctr_en, mask, clr, cnt_wr, inc, wrap, stat;
  logic [LANE_W-1:0]        code [NUM_CTR];
  logic [CTR_W-1:0]         cnt  [NUM_CTR];
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;

  evt_regs #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i[31:0]),
    .glb_en_o (glb_en),
    .ctr_en_o (ctr_en),
    .mask_o   (mask),
    .clr_o    (clr),
    .cnt_wr_o (cnt_wr),
    .code_o   (code)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic [LANE_W-1:0] c;
    logic              code_ok;
    assign c       = code[k];
    assign code_ok = ({{(32-LANE_W){1'b0}}, c} < 32'(NUM_EVT));
    assign inc[k]  = glb_en & ctr_en[k] & code_ok & evt_i[c[IDX_W-1:0]];

    evt_counter #(.CTR_W(CTR_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[k]),
      .wr_i    (cnt_wr[k]),
      .wdata_i (wdata_i),
      .cnt_o   (cnt[k]),
      .wrap_o  (wrap[k])
    );
    assign cnt_flat[k*CTR_W +: CTR_W] = cnt[k];
  end

  evt_irq #(.NUM_CTR(NUM_CTR)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .clr_i  (clr),
    .mask_i (mask),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CTRL)) rdata_o = CTR_W'(glb_en);
    if (addr_i == ADDR_W'(OFF_CEN))  rdata_o = CTR_W'(ctr_en);
    if (addr_i == ADDR_W'(OFF_MASK)) rdata_o = CTR_W'(mask);
    if (addr_i == ADDR_W'(OFF_STAT)) rdata_o = CTR_W'(stat);
    if (addr_i == ADDR_W'(OFF_VER))  rdata_o = CTR_W'(VERSION);
    for (int k = 0; k < NUM_CTR; k++) begin
      if (addr_i == ADDR_W'(OFF_SEL + 4*(k/LANES)))
        rdata_o[(k%LANES)*LANE_W +: LANE_W] = code[k];
      if (addr_i == ADDR_W'(OFF_CNT + 8*k))
        rdata_o = cnt[k];
    end
  end
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk #(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     glb_en_i,
  input logic [NUM_CTR-1:0]       inc_i,
  input logic [NUM_CTR-1:0]       wr_i,
  input logic [NUM_CTR-1:0]       wrap_i,
  input logic [CTR_W-1:0]         wdata_i,
  input logic [NUM_CTR*CTR_W-1:0] cnt_i,
  input logic [NUM_CTR-1:0]       stat_i,
  input logic [NUM_CTR-1:0]       mask_i,
  input logic                     irq_i
);
  for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
    // R2
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i[k] && !wr_i[k]) |=> $stable(cnt_i[k*CTR_W +: CTR_W]));
    // R2
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i[k] && !wr_i[k]) |=>
        cnt_i[k*CTR_W +: CTR_W] == $past(cnt_i[k*CTR_W +: CTR_W]) + CTR_W'(1));
    // R3
    glb_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!glb_en_i && !wr_i[k]) |=> $stable(cnt_i[k*CTR_W +: CTR_W]));
    // R6
    wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i[k] |=> cnt_i[k*CTR_W +: CTR_W] == $past(wdata_i));
    // R7
    stat_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_i[k]) |-> $past(wrap_i[k]));
    // R9
    wrap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_i[k] |=> stat_i[k]);
  end

  // R8
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i == '0) |-> !irq_i);
  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '1) |-> !irq_i);
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .glb_en_i (glb_en),
  .inc_i    (inc),
  .wr_i     (cnt_wr),
  .wrap_i   (wrap),
  .wdata_i  (wdata_i),
  .cnt_i    (cnt_flat),
  .stat_i   (stat),
  .mask_i   (mask),
  .irq_i    (irq_o)
);

// File: tb/sim_evt_ctr_bank.sv
module sim_evt_ctr_bank;
  localparam int NEV = 128;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NEV-1:0] evt_i = '0;
  logic           req_i = 1'b0;
  logic           we_i = 1'b0;
  logic [11:0]    addr_i = '0;
  logic [63:0]    wdata_i = '0;
  logic [63:0]    rdata_o;
  logic           irq_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  logic [63:0] m_cnt  [8];
  logic [7:0]  m_code [8];
  logic        m_glb;
  logic [7:0]  m_en, m_mask, m_stat;

  evt_ctr_bank u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // expected next state from the register map and counting rules
  task automatic model_update(input logic [NEV-1:0] ev, input logic w,
                              input logic [11:0] a, input logic [63:0] d);
    logic [7:0] wrp = '0;
    logic [7:0] clr = '0;
    for (int k = 0; k < 8; k++) begin
      logic inc = m_glb && m_en[k] && (m_code[k] < 8'h80) && ev[m_code[k][6:0]];
      if (w && a == 12'(256 + 8*k)) m_cnt[k] = d;
      else if (inc) begin
        if (m_cnt[k] == '1) wrp[k] = 1'b1;
        m_cnt[k] = m_cnt[k] + 64'd1;
      end
    end
    if (w && a == 12'h010) clr = d[7:0];
    m_stat = (m_stat & ~clr) | wrp;
    if (w) begin
      if (a == 12'h000) m_glb = d[0];
      if (a == 12'h004) m_en = d[7:0];
      if (a == 12'h008) m_mask = d[7:0];
      if (a == 12'h020) for (int j = 0; j < 4; j++) m_code[j] = d[j*8 +: 8];
      if (a == 12'h024) for (int j = 0; j < 4; j++) m_code[4+j] = d[j*8 +: 8];
    end
  endtask

  task automatic step(input logic [NEV-1:0] ev, input logic w,
                      input logic [11:0] a, input logic [63:0] d);
    @(negedge clk_i);
    evt_i = ev; req_i = w; we_i = w; addr_i = a; wdata_i = d;
    model_update(ev, w, a, d);
    @(posedge clk_i);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    step('0, 1'b1, a, d);
  endtask

  task automatic pulse(input logic [NEV-1:0] ev, input int n);
    for (int i = 0; i < n; i++) step(ev, 1'b0, 12'h0, 64'h0);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [63:0] exp);
    @(negedge clk_i);
    evt_i = '0; req_i = 1'b0; we_i = 1'b0; addr_i = a;
    #1 chk(tag, rdata_o, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk_i);
    evt_i = '0; req_i = 1'b0; we_i = 1'b0;
    #1 chk(tag, {63'd0, irq_o}, {63'd0, exp});
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 8; k++) rd_chk(tag, 12'(256 + 8*k), m_cnt[k]);
    rd_chk(tag, 12'h00C, {56'd0, m_stat});
    irq_chk(tag, |(m_stat & ~m_mask));
  endtask

  function automatic logic [NEV-1:0] one(input int idx);
    return NEV'(1) << idx;
  endfunction

  function automatic logic [NEV-1:0] rnd_ev();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) begin m_cnt[k] = '0; m_code[k] = '0; end
    m_glb = 1'b0; m_en = '0; m_mask = 8'hFF; m_stat = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    rd_chk("R1", 12'h000, 64'd0);
    rd_chk("R1", 12'h004, 64'd0);
    rd_chk("R1", 12'h008, 64'hFF);
    rd_chk("R1", 12'h00C, 64'd0);
    rd_chk("R1", 12'h100, 64'd0);
    rd_chk("R1", 12'h138, 64'd0);
    irq_chk("R1", 1'b0);

    // R10 identifier, write ignored
    rd_chk("R10", 12'h014, 64'h0002_0001);
    wr(12'h014, 64'hDEAD_BEEF);
    rd_chk("R10", 12'h014, 64'h0002_0001);

    // codes: c0=09 c1=30 c2=31 c3=34 c4=35 c5=80 c6=7F c7=00
    wr(12'h020, 64'h3431_3009);
    wr(12'h024, 64'h007F_8035);
    rd_chk("R2", 12'h024, 64'h007F_8035);
    wr(12'h004, 64'hFF);
    wr(12'h000, 64'h1);

    // R2 lane selection
    pulse(one('h30), 5);
    rd_chk("R2", 12'h108, 64'd5);
    rd_chk("R2", 12'h100, 64'd0);
    rd_chk("R2", 12'h118, 64'd0);

    // R4 invalid code never counts
    pulse('1, 4);
    rd_chk("R4", 12'h128, 64'd0);
    rd_chk("R2", 12'h130, 64'd4);

    // R3 global and per-counter enable
    wr(12'h000, 64'h0);
    pulse('1, 3);
    rd_chk("R3", 12'h130, 64'd4);
    wr(12'h000, 64'h1);
    wr(12'h004, 64'hBF);
    pulse('1, 2);
    rd_chk("R3", 12'h130, 64'd4);
    rd_chk("R3", 12'h138, 64'd6);

    // R5 R7 R8 preset near wrap, masked then unmasked
    wr(12'h110, 64'hFFFF_FFFF_FFFF_FFFE);
    rd_chk("R5", 12'h110, 64'hFFFF_FFFF_FFFF_FFFE);
    pulse(one('h31), 3);
    rd_chk("R7", 12'h110, 64'd1);
    rd_chk("R7", 12'h00C, 64'h04);
    irq_chk("R8", 1'b0);
    wr(12'h008, 64'hFB);
    irq_chk("R8", 1'b1);
    rd_chk("R8", 12'h00C, 64'h04);

    // R9 clear
    wr(12'h010, 64'h02);
    rd_chk("R9", 12'h00C, 64'h04);
    wr(12'h010, 64'h04);
    rd_chk("R9", 12'h00C, 64'h00);
    irq_chk("R9", 1'b0);

    // R6 write beats increment
    step(one('h34), 1'b1, 12'h118, 64'h1234);
    rd_chk("R6", 12'h118, 64'h1234);

    // R9 wrap in clear cycle keeps bit
    wr(12'h100, 64'hFFFF_FFFF_FFFF_FFFF);
    step(one('h09), 1'b1, 12'h010, 64'h01);
    rd_chk("R9", 12'h00C, 64'h01);
    rd_chk("R7", 12'h100, 64'd0);
    wr(12'h010, 64'hFF);

    // random phase
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 300; c++) begin
        int sel = $urandom % 40;
        logic [63:0] d = {$urandom, $urandom};
        case (sel)
          0: step(rnd_ev(), 1'b1, 12'h000, d);
          1: step(rnd_ev(), 1'b1, 12'h004, d);
          2: step(rnd_ev(), 1'b1, 12'h008, d);
          3: step(rnd_ev(), 1'b1, 12'h010, d);
          4: step(rnd_ev(), 1'b1, 12'h020, d);
          5: step(rnd_ev(), 1'b1, 12'h024, d);
          6: step(rnd_ev(), 1'b1, 12'(256 + 8*($urandom % 8)),
                  64'hFFFF_FFFF_FFFF_FFC0 | {58'd0, d[5:0]});
          default: step(rnd_ev(), 1'b0, 12'h0, 64'h0);
        endcase
      end
      check_all("R2");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule